// File: doc/BRIEF.md
# Multi-Input Fault Capture Unit

The unit takes eight asynchronous fault inputs and turns each one into a registered active-fault flag. Every input first passes through a two-stage synchronizer. An optional per-input glitch filter can come next. A per-input polarity bit then decides which level counts as a fault. A per-input mode bit selects one of two behaviours. In transparent mode the flag follows the conditioned input. In latched mode the flag holds until software has acknowledged the fault.

Software reaches the unit through a plain write port (enable, address, data) and a combinational read port. There are three locations:

- **Configuration word.** It carries the polarity, mode and filter fields. Two write-protect inputs, one driven by software and one by hardware, can lock it.
- **Acknowledge register.** It is write-one-to-clear and releases latched faults.
- **Status word.** It returns the eight flags.

Polarity should be programmed before latched mode is enabled. Otherwise a transient false condition gets captured.

Top module: `fault_capture`

## Requirements
- R1: The configuration word sits at address 0. Polarity is in bits 7:0, mode is in bits 15:8 and filter enable is in bits 23:16 (bit y of each field belongs to input y). Bits 31:24 always read as zero. The word is all zeros after reset.
- R2: A write to address 0 is discarded while `sw_wp` or `hw_wp` is high.
- R3: With a polarity bit of 0 the condition for that input is a low level. With a polarity bit of 1 it is a high level.
- R4: With a mode bit of 0 the flag follows the condition. With the filter off, a change on `fault_in` shows on `fault_active` three rising edges after the input change, and not earlier.
- R5: With a mode bit of 1 the flag is set by the condition. It drops only once the condition is gone and a 1 has been written to that bit of the acknowledge register, in either order. An acknowledge written while the condition is present is remembered, and the flag then falls on the first edge at which the condition is absent.
- R6: With a filter bit of 1 the synchronized input must hold a new level for three consecutive cycles before it is used. Shorter pulses are dropped, and a held change reaches the flag after six rising edges.
- R7: An acknowledge bit written for an input that is not latched, or whose flag is clear, has no effect now and is not remembered for a later fault.
- R8: The acknowledge register is at address 1 and reads as zero. The status flags read at address 2 in bits 7:0. Address 3 reads as zero. Writes to addresses other than 0 leave the configuration word unchanged.
- R9: During and after reset, with all inputs held high and the reset configuration, every flag is 0. The synchronizer and filter stages start at the high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write address (0 config, 1 acknowledge) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| sw_wp | input | 1 | Software write-protect for the configuration word |
| hw_wp | input | 1 | Hardware write-protect for the configuration word |
| fault_in | input | 8 | Asynchronous fault inputs |
| fault_active | output | 8 | Per-input active-fault flags |

## Verification
The bench exercises both orders of releasing a latched fault. A design that forgets an early acknowledge keeps the flag set forever. A design that honours an acknowledge while the condition is still present drops the flag too soon.

Two-cycle glitches must vanish under the filter, while a pulse of exactly three cycles must pass. An off-by-one filter counter flips one of these outcomes. The exact three-edge and six-edge latencies are sampled on both sides of the change.

Acknowledges aimed at idle or transparent inputs are followed by a real fault. A design that stores such a clear would release that fault early. Protected writes that would flip polarity are also checked, because a leaky protect raises every flag.

// File: rtl/fltcap_pkg.sv
package fltcap_pkg;

    localparam int NUM_FAULTS  = 8;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 2;
    localparam int FILT_HOLD   = 3;
    localparam int SYNC_STAGES = 2;
    localparam logic IDLE_LEVEL = 1'b1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG    = 2'd0,
        SEL_ACK    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Field order is the software-visible layout: filter high, polarity low.
    typedef struct packed {
        logic [NUM_FAULTS-1:0] filt_en;
        logic [NUM_FAULTS-1:0] latch_en;
        logic [NUM_FAULTS-1:0] pol;
    } fault_cfg_t;

    localparam int CFG_W = $bits(fault_cfg_t);

    function automatic fault_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
        return fault_cfg_t'(w);
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input fault_cfg_t c);
        return {{(DATA_W-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/fltcap_sync.sv
module fltcap_sync #(
    parameter int   N       = fltcap_pkg::NUM_FAULTS,
    parameter int   STAGES  = fltcap_pkg::SYNC_STAGES,
    parameter logic RST_VAL = fltcap_pkg::IDLE_LEVEL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= {N{RST_VAL}};
            end
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fltcap_filter.sv
module fltcap_filter #(
    parameter int   N       = fltcap_pkg::NUM_FAULTS,
    parameter int   HOLD    = fltcap_pkg::FILT_HOLD,
    parameter logic RST_VAL = fltcap_pkg::IDLE_LEVEL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_i,
    output logic [N-1:0] filt_o
);

    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

    logic [N-1:0] filt_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q     <= '0;
                filt_q[i] <= RST_VAL;
            end else if (sync_i[i] == filt_q[i]) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                cnt_q     <= '0;
                filt_q[i] <= sync_i[i];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        // A new filtered level must have been seen on the input three cycles running
        AST_FILTER_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
            $changed(filt_q[i]) |->
                ($past(sync_i[i], 1) == filt_q[i]) &&
                ($past(sync_i[i], 2) == filt_q[i]) &&
                ($past(sync_i[i], 3) == filt_q[i])) else $error("filter hold"); // R6
    end

    assign filt_o = filt_q;

endmodule

// File: rtl/fltcap_latch.sv
module fltcap_latch #(
    parameter int N = fltcap_pkg::NUM_FAULTS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] latch_en_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic flag_d;
        logic pend_d;

        always_comb begin
            if (cond_i[i]) begin
                flag_d = 1'b1;
            end else if (latch_en_i[i]) begin
                flag_d = flag_q[i] & ~(pend_q[i] | ack_i[i]);
            end else begin
                flag_d = 1'b0;
            end
            pend_d = flag_d & latch_en_i[i] & (pend_q[i] | (ack_i[i] & flag_q[i]));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                flag_q[i] <= flag_d;
                pend_q[i] <= pend_d;
            end
        end

        AST_LATCH_HOLDS_UNTIL_ACKED: assert property (@(posedge clk) disable iff (rst)
            (latch_en_i[i] && flag_q[i] && !pend_q[i] && !ack_i[i]) |=> flag_q[i])
            else $error("latched flag released without acknowledge"); // R5

        AST_IDLE_ACK_NOT_KEPT: assert property (@(posedge clk) disable iff (rst)
            (ack_i[i] && !flag_q[i]) |=> !pend_q[i])
            else $error("acknowledge on idle fault remembered"); // R7
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fltcap_regs.sv
module fltcap_regs
    import fltcap_pkg::*;
#(
    parameter int N = NUM_FAULTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sw_wp,
    input  logic              hw_wp,
    input  logic [N-1:0]      status_i,
    output fault_cfg_t        cfg_o,
    output logic [N-1:0]      ack_o
);

    fault_cfg_t cfg_q;
    reg_sel_e   wr_sel;
    reg_sel_e   rd_sel;
    logic       cfg_wr;
    logic       unused_hi;

    assign wr_sel    = reg_sel_e'(wr_addr);
    assign rd_sel    = reg_sel_e'(rd_addr);
    assign cfg_wr    = wr_en && (wr_sel == SEL_CFG) && !(sw_wp || hw_wp);
    assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_from_word(wr_data[CFG_W-1:0]);
        end
    end

    assign ack_o = (wr_en && (wr_sel == SEL_ACK)) ? wr_data[N-1:0] : '0;
    assign cfg_o = cfg_q;

    always_comb begin
        unique case (rd_sel)
            SEL_CFG:    rd_data = cfg_to_word(cfg_q);
            SEL_STATUS: rd_data = {{(DATA_W-N){1'b0}}, status_i};
            default:    rd_data = '0;
        endcase
    end

    AST_WP_BLOCKS_CFG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_CFG) && (sw_wp || hw_wp)) |=> $stable(cfg_q))
        else $error("protected write changed config"); // R2

    AST_OTHER_WR_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel != SEL_CFG)) |=> $stable(cfg_q))
        else $error("non-config write changed config"); // R8

endmodule

// File: rtl/fault_capture.sv
module fault_capture
    import fltcap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  sw_wp,
    input  logic                  hw_wp,
    input  logic [NUM_FAULTS-1:0] fault_in,
    output logic [NUM_FAULTS-1:0] fault_active
);

    localparam int N = NUM_FAULTS;

    fault_cfg_t   cfg;
    logic [N-1:0] sync_w;
    logic [N-1:0] filt_w;
    logic [N-1:0] level_w;
    logic [N-1:0] cond_w;
    logic [N-1:0] ack_w;
    logic [N-1:0] flag_w;

    fltcap_sync #(.N(N), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (fault_in),
        .sync_o  (sync_w)
    );

    fltcap_filter #(.N(N), .HOLD(FILT_HOLD), .RST_VAL(IDLE_LEVEL)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_w),
        .filt_o (filt_w)
    );

    // Filter sits ahead of polarity, so its state is independent of the polarity setting
    assign level_w = (cfg.filt_en & filt_w) | (~cfg.filt_en & sync_w);
    assign cond_w  = level_w ~^ cfg.pol;

    fltcap_latch #(.N(N)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond_w),
        .latch_en_i (cfg.latch_en),
        .ack_i      (ack_w),
        .flag_o     (flag_w)
    );

    fltcap_regs #(.N(N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sw_wp    (sw_wp),
        .hw_wp    (hw_wp),
        .status_i (flag_w),
        .cfg_o    (cfg),
        .ack_o    (ack_w)
    );

    assign fault_active = flag_w;

endmodule

// File: tb/sim_fault_capture.sv
module sim_fault_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        sw_wp;
    logic        hw_wp;
    logic [7:0]  fault_in;
    logic [7:0]  fault_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fault_capture u0 (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .sw_wp        (sw_wp),
        .hw_wp        (hw_wp),
        .fault_in     (fault_in),
        .fault_active (fault_active)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cfg(input logic [7:0] pol, input logic [7:0] mode, input logic [7:0] filt);
        wr(2'd0, {8'h00, filt, mode, pol});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1; fault_in = 8'hFF;
        tick(3);
        chk("R9", "flags in reset", {24'h0, fault_active}, 32'h0);
        rd(2'd0, d); chk("R1", "config after reset", d, 32'h0);
        rst = 1'b0;
        tick(4);
        chk("R9", "flags after reset", {24'h0, fault_active}, 32'h0);
        rd(2'd2, d); chk("R9", "status after reset", d, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(2'd0, 32'hFF123400);
        rd(2'd0, d); chk("R1", "field readback, top byte zero", d, 32'h00123400);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R1", "config cleared", d, 32'h0);
    endtask

    task automatic t_polarity();
        cfg(8'h0F, 8'h00, 8'h00);
        tick(3);
        chk("R3", "high inputs, mixed polarity", {24'h0, fault_active}, 32'h0F);
        fault_in = 8'h00;
        tick(2);
        chk("R4", "no change after two edges", {24'h0, fault_active}, 32'h0F);
        tick(1);
        chk("R4", "change after three edges", {24'h0, fault_active}, 32'hF0);
        fault_in = 8'h3C;
        tick(3);
        chk("R3", "pattern 3C", {24'h0, fault_active}, 32'hCC);
        fault_in = 8'h00;
        cfg(8'hFF, 8'h00, 8'h00);
        tick(4);
        chk("R3", "quiet state", {24'h0, fault_active}, 32'h0);
    endtask

    task automatic t_latch_order();
        cfg(8'hFF, 8'hFF, 8'h00);
        tick(2);
        fault_in = 8'h04;
        tick(3);
        chk("R5", "latched set", {24'h0, fault_active}, 32'h04);
        fault_in = 8'h00;
        tick(4);
        chk("R5", "held after condition gone", {24'h0, fault_active}, 32'h04);
        wr(2'd1, 32'h04);
        chk("R5", "released by acknowledge", {24'h0, fault_active}, 32'h00);
        fault_in = 8'h20;
        tick(3);
        chk("R5", "second latched set", {24'h0, fault_active}, 32'h20);
        wr(2'd1, 32'h20);
        tick(2);
        chk("R5", "early ack keeps flag while present", {24'h0, fault_active}, 32'h20);
        fault_in = 8'h00;
        tick(2);
        chk("R5", "still set two edges after removal", {24'h0, fault_active}, 32'h20);
        tick(1);
        chk("R5", "remembered ack releases", {24'h0, fault_active}, 32'h00);
    endtask

    task automatic t_ack_ignored();
        cfg(8'hFF, 8'h08, 8'h00);
        wr(2'd1, 32'h08);
        fault_in = 8'h0A;
        tick(3);
        chk("R7", "both set", {24'h0, fault_active}, 32'h0A);
        wr(2'd1, 32'h02);
        chk("R7", "ack on transparent fault ignored", {24'h0, fault_active}, 32'h0A);
        fault_in = 8'h00;
        tick(4);
        chk("R7", "idle ack not remembered", {24'h0, fault_active}, 32'h08);
        wr(2'd1, 32'h08);
        chk("R5", "release after condition gone", {24'h0, fault_active}, 32'h00);
        cfg(8'hFF, 8'h00, 8'h00);
    endtask

    task automatic t_filter();
        int bad = 0;
        cfg(8'hFF, 8'h00, 8'h01);
        tick(8);
        fault_in = 8'h01;
        tick(2);
        fault_in = 8'h00;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (fault_active[0] !== 1'b0) bad++;
        end
        chk("R6", "two-cycle glitch suppressed", bad, 0);
        fault_in = 8'h01;
        tick(3);
        fault_in = 8'h00;
        tick(2);
        chk("R6", "three-cycle pulse edge 5", {24'h0, fault_active}, 32'h00);
        tick(1);
        chk("R6", "three-cycle pulse edge 6", {24'h0, fault_active}, 32'h01);
        tick(2);
        chk("R6", "pulse edge 8", {24'h0, fault_active}, 32'h01);
        tick(1);
        chk("R6", "pulse edge 9", {24'h0, fault_active}, 32'h00);
        fault_in = 8'h03;
        tick(3);
        chk("R4", "unfiltered input at edge 3", {24'h0, fault_active}, 32'h02);
        tick(2);
        chk("R6", "filtered input not yet at edge 5", {24'h0, fault_active}, 32'h02);
        tick(1);
        chk("R6", "filtered input at edge 6", {24'h0, fault_active}, 32'h03);
        fault_in = 8'h00;
        tick(3);
        chk("R6", "release: unfiltered first", {24'h0, fault_active}, 32'h01);
        tick(3);
        chk("R6", "release: filtered later", {24'h0, fault_active}, 32'h00);
        cfg(8'hFF, 8'h00, 8'h00);
        tick(8);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        sw_wp = 1'b1;
        wr(2'd0, 32'h00000000);
        rd(2'd0, d); chk("R2", "software protect", d, 32'h000000FF);
        sw_wp = 1'b0; hw_wp = 1'b1;
        wr(2'd0, 32'h00000000);
        rd(2'd0, d); chk("R2", "hardware protect", d, 32'h000000FF);
        tick(4);
        chk("R2", "no flags from blocked polarity", {24'h0, fault_active}, 32'h0);
        hw_wp = 1'b0;
        wr(2'd0, 32'h000100FF);
        rd(2'd0, d); chk("R2", "write after unprotect", d, 32'h000100FF);
        cfg(8'hFF, 8'h00, 8'h00);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(2'd1, 32'hFF);
        rd(2'd1, d); chk("R8", "acknowledge reads zero", d, 32'h0);
        rd(2'd3, d); chk("R8", "spare reads zero", d, 32'h0);
        rd(2'd0, d); chk("R8", "ack write left config", d, 32'h000000FF);
        fault_in = 8'h81;
        tick(3);
        rd(2'd2, d); chk("R8", "status word", d, 32'h00000081);
        chk("R8", "flag port", {24'h0, fault_active}, 32'h81);
        fault_in = 8'h00;
        tick(4);
    endtask

    initial begin
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        sw_wp = 1'b0; hw_wp = 1'b0; rst = 1'b1; fault_in = 8'hFF;
        @(negedge clk);
        t_reset();
        t_layout();
        t_polarity();
        t_latch_order();
        t_ack_ignored();
        t_filter();
        t_protect();
        t_readback();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule